// File: doc/BRIEF.md
# Packet Page Allocator with Command-Driven Queues

This block manages a small pool of fixed-size packet pages in the buffer memory of an Ethernet MAC. It keeps a bitmap of pages in use and three queues of page numbers: pages waiting to be sent, pages already sent and awaiting host review, and pages holding received frames. The host drives it with 3-bit commands, a packet-number register, and acknowledge and mask writes to an interrupt status register. One interrupt line results from these.

The receive side asks for a page with a single-cycle request. It gets the lowest free page in the same cycle, and that page is pushed onto the receive queue. The transmit side drains the send queue one page per cycle whenever transmit is enabled and no command is being applied. It reports each page on a launch strobe. A transmit allocation that finds no free page stays pending. It is retried on every later page release.

Top module: `pkt_page_alloc`

## Requirements
- R1: After reset, int_status is 0x04, int_mask is 0, irq is low, alloc_result is 0, pages_used is 0, and both rx_head and done_head read 0x80.
- R2: Every allocation takes the lowest-numbered free page. The failure and empty sentinel is 0x80. pages_used counts the pages in use.
- R3: Command 1 (transmit allocate) places the page in alloc_result and sets the ALLOC status bit (0x08) on success. On failure it sets alloc_result to 0x80, clears ALLOC and leaves the request pending. Each later page release retries the pending request, and a successful retry sets ALLOC.
- R4: A receive request is granted (rx_alloc_ok) only when a page is free and command 2 is not applied in the same cycle. A granted page is pushed onto the receive queue and sets RCV (0x01).
- R5: Command 3 pops the receive queue. Command 4 first frees the head page of the receive queue and then pops it. After either pop, RCV is 1 if entries remain and 0 otherwise.
- R6: Command 5 frees the page named by the packet-number register. A register value of NUM_PAGES or more is ignored. The register reads back what was written.
- R7: Command 6 appends the packet-number register to the send queue. The command is ignored when the send queue is full or when the value is not a valid page.
- R8: When tx_en is high, the send queue is not empty and cmd_valid is low, tx_launch pulses for one cycle. tx_page shows the head page, and that page is removed from the send queue.
- R9: With auto_release high, a launched page is freed. Otherwise it is appended to the completion queue. done_head shows the oldest completed page, or 0x80 when that queue is empty.
- R10: TX_EMPTY (0x04) is set whenever the send queue is empty. Once set, it stays set until it is acknowledged. TX (0x02) reads 1 whenever the completion queue is not empty.
- R11: An acknowledge write clears only the status bits present in both the written value and 0xD6, so ALLOC and RCV are unaffected. Writing bit 0x02 also removes the head of the completion queue.
- R12: irq is high exactly when int_status AND int_mask is nonzero. A mask write replaces int_mask.
- R13: Command 2 empties all three queues and the bitmap, and cancels any pending allocation (alloc_result becomes 0). Command 7 empties the send and completion queues only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 3 | Command code (0..7) |
| pnum_we | input | 1 | Packet-number register write |
| pnum_wdata | input | PW | Packet-number write value |
| pnum | output | PW | Packet-number register |
| alloc_result | output | PW | Transmit allocation result or 0x80 |
| pages_used | output | CW | Number of allocated pages |
| rx_alloc_req | input | 1 | Receive page request |
| rx_alloc_ok | output | 1 | Receive request granted this cycle |
| rx_alloc_page | output | PW | Page offered to the receive side |
| rx_head | output | PW | Receive queue head or 0x80 |
| done_head | output | PW | Completion queue head or 0x80 |
| tx_en | input | 1 | Transmit enable |
| auto_release | input | 1 | Free pages as they are launched |
| tx_launch | output | 1 | One-cycle launch strobe |
| tx_page | output | PW | Page being launched |
| ack_we | input | 1 | Interrupt acknowledge write |
| ack_data | input | 8 | Bits to acknowledge |
| mask_we | input | 1 | Interrupt mask write |
| mask_data | input | 8 | New interrupt mask |
| int_status | output | 8 | Interrupt status |
| int_mask | output | 8 | Interrupt mask |
| irq | output | 1 | Interrupt line |

## Verification
Several properties are checked on every cycle. irq always follows status AND mask. A launch never happens without tx_en or while a command is applied. ALLOC, after an allocate command, agrees with whether the result is the sentinel, and only that command can clear it. A granted receive page always lies in range and leaves the receive queue non-empty. Queue ordering, the lowest-free choice, retry of a deferred allocation after a release, ignored pushes on a full send queue and the acknowledge side effects all depend on sequences of commands, so only the directed scenarios can show them.

// File: rtl/pga_pkg.sv
// Package: command codes, status bit positions and the sentinel value shared
// by the page allocator and its checker.
package pga_pkg;

    typedef enum logic [2:0] {
        CMD_NOP       = 3'd0,
        CMD_TX_ALLOC  = 3'd1,
        CMD_MMU_RESET = 3'd2,
        CMD_RX_POP    = 3'd3,
        CMD_RX_FREE   = 3'd4,
        CMD_FREE      = 3'd5,
        CMD_TX_QUEUE  = 3'd6,
        CMD_TX_CLEAR  = 3'd7
    } cmd_e;

    localparam logic [7:0] ST_ALLOC   = 8'h08;
    localparam logic [7:0] ST_TXEMPTY = 8'h04;
    localparam logic [7:0] ST_TX      = 8'h02;
    localparam logic [7:0] ST_RCV     = 8'h01;
    localparam logic [7:0] ACK_MASK   = 8'hD6;
    localparam logic [7:0] NO_PAGE    = 8'h80;

endpackage

// File: rtl/page_fifo.sv
// Shift-register queue of page numbers. The head is always entry 0.
// Assumes: push and pop may coincide; a pop on an empty queue does nothing;
// a push into a full queue is dropped unless a pop frees a slot in the same
// cycle; clear has priority over push and pop.
module page_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full
);

    logic [W-1:0]  ent   [DEPTH];
    logic [W-1:0]  shl   [DEPTH];
    logic [W-1:0]  ent_n [DEPTH];
    logic [CW-1:0] cnt_n;
    logic          do_pop;
    logic          do_push;
    logic [CW-1:0] wr_idx;

    // Shifted view of the entries, used when the head is removed
    for (genvar g = 0; g < DEPTH; g++) begin : g_shift
        if (g < DEPTH - 1) begin : g_mid
            assign shl[g] = ent[g+1];
        end else begin : g_last
            assign shl[g] = '0;
        end
    end

    assign empty  = (count == '0);
    assign full   = (count == CW'(DEPTH));
    assign head   = ent[0];
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign wr_idx  = do_pop ? count - CW'(1) : count;

    // Next entries and count after this cycle's pop and push
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            ent_n[i] = do_pop ? shl[i] : ent[i];
            if (do_push && (CW'(i) == wr_idx)) begin
                ent_n[i] = push_data;
            end
        end
        cnt_n = count + CW'(do_push) - CW'(do_pop);
    end

    // Queue storage and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            count <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                ent[i] <= '0;
            end
        end else begin
            count <= cnt_n;
            for (int i = 0; i < DEPTH; i++) begin
                ent[i] <= ent_n[i];
            end
        end
    end

endmodule

// File: rtl/page_map.sv
// Allocation bitmap: one bit per page, set when allocated.
// Assumes: set wins over clear for the same bit in one cycle; clear empties
// the whole map.
module page_map #(
    parameter int N   = 4,
    localparam int UW = $clog2(N + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic [N-1:0]  set_mask,
    input  logic [N-1:0]  clr_mask,
    output logic [N-1:0]  used,
    output logic [UW-1:0] used_count
);

    // Bitmap update
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            used <= '0;
        end else begin
            used <= (used & ~clr_mask) | set_mask;
        end
    end

    // Population count of allocated pages
    always_comb begin
        used_count = '0;
        for (int i = 0; i < N; i++) begin
            used_count = used_count + UW'(used[i]);
        end
    end

endmodule

// File: rtl/page_pick.sv
// Lowest-free-page finder. Reports the page number (sentinel when none),
// a found flag and a one-hot mask of the chosen page.
// Assumes: N is at most 128, so page numbers never collide with the sentinel.
module page_pick
    import pga_pkg::*;
#(
    parameter int N = 4,
    parameter int W = 8
) (
    input  logic [N-1:0] used,
    output logic [W-1:0] page,
    output logic         found,
    output logic [N-1:0] onehot
);

    // Scan from the top so the lowest free page is the last one written
    always_comb begin
        page   = W'(NO_PAGE);
        found  = 1'b0;
        onehot = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!used[i]) begin
                page   = W'(i);
                found  = 1'b1;
                onehot = '0;
                onehot[i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/pkt_page_alloc.sv
// Packet page allocator: bitmap, send/completion/receive queues, host command
// decode, deferred transmit allocation and interrupt status.
// Assumes: one host command per cycle; launches stall while any command is
// applied; a receive grant and a transmit allocation in the same cycle take
// different pages (the receive side picks first).
module pkt_page_alloc
    import pga_pkg::*;
#(
    parameter int NUM_PAGES = 4,
    parameter int PW        = 8,
    localparam int CW       = $clog2(NUM_PAGES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_code,
    input  logic          pnum_we,
    input  logic [PW-1:0] pnum_wdata,
    output logic [PW-1:0] pnum,
    output logic [PW-1:0] alloc_result,
    output logic [CW-1:0] pages_used,
    input  logic          rx_alloc_req,
    output logic          rx_alloc_ok,
    output logic [PW-1:0] rx_alloc_page,
    output logic [PW-1:0] rx_head,
    output logic [PW-1:0] done_head,
    input  logic          tx_en,
    input  logic          auto_release,
    output logic          tx_launch,
    output logic [PW-1:0] tx_page,
    input  logic          ack_we,
    input  logic [7:0]    ack_data,
    input  logic          mask_we,
    input  logic [7:0]    mask_data,
    output logic [7:0]    int_status,
    output logic [7:0]    int_mask,
    output logic          irq
);

    localparam logic [PW-1:0] SENT = PW'(NO_PAGE);

    cmd_e                cmd;
    logic                pnum_ok;
    logic [NUM_PAGES-1:0] bm;
    logic [NUM_PAGES-1:0] rx_oh;
    logic                rx_found;
    logic [NUM_PAGES-1:0] rel_mask;
    logic [NUM_PAGES-1:0] rx_set;
    logic [NUM_PAGES-1:0] after_bm;
    logic [PW-1:0]       tx_pg;
    logic                tx_found;
    logic [NUM_PAGES-1:0] tx_oh;
    logic [NUM_PAGES-1:0] tx_set;
    logic                try_tx;
    logic                alloc_pend;
    logic                launch;
    logic                mmu_clear;
    logic                tx_clear;
    logic [7:0]          stat_q;
    logic [7:0]          stat_n;

    logic [PW-1:0] rxq_head, txq_head, dq_head;
    logic [CW-1:0] rxq_cnt, txq_cnt, dq_cnt;
    logic          rxq_empty, txq_empty, dq_empty;
    logic          rxq_full, txq_full, dq_full;

    assign cmd       = cmd_valid ? cmd_e'(cmd_code) : CMD_NOP;
    assign pnum_ok   = pnum < PW'(NUM_PAGES);
    assign mmu_clear = (cmd == CMD_MMU_RESET);
    assign tx_clear  = mmu_clear || (cmd == CMD_TX_CLEAR);
    assign launch    = tx_en && !txq_empty && !cmd_valid;

    // Bitmap of allocated pages
    page_map #(.N(NUM_PAGES)) u_map (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (mmu_clear),
        .set_mask   (rx_set | tx_set),
        .clr_mask   (rel_mask),
        .used       (bm),
        .used_count (pages_used)
    );

    // Receive side picks from the current bitmap
    page_pick #(.N(NUM_PAGES), .W(PW)) u_rx_pick (
        .used   (bm),
        .page   (rx_alloc_page),
        .found  (rx_found),
        .onehot (rx_oh)
    );

    assign rx_alloc_ok = rx_alloc_req && rx_found && !mmu_clear;
    assign rx_set      = rx_alloc_ok ? rx_oh : '0;

    // Pages freed this cycle by receive release, explicit release or launch
    always_comb begin
        rel_mask = '0;
        for (int i = 0; i < NUM_PAGES; i++) begin
            if ((cmd == CMD_RX_FREE) && !rxq_empty && (rxq_head == PW'(i))) begin
                rel_mask[i] = 1'b1;
            end
            if ((cmd == CMD_FREE) && (pnum == PW'(i))) begin
                rel_mask[i] = 1'b1;
            end
            if (launch && auto_release && (txq_head == PW'(i))) begin
                rel_mask[i] = 1'b1;
            end
        end
    end

    assign after_bm = (bm & ~rel_mask) | rx_set;

    // Transmit side picks after this cycle's releases and receive grant
    page_pick #(.N(NUM_PAGES), .W(PW)) u_tx_pick (
        .used   (after_bm),
        .page   (tx_pg),
        .found  (tx_found),
        .onehot (tx_oh)
    );

    assign try_tx = (cmd == CMD_TX_ALLOC) || (alloc_pend && (rel_mask != '0));
    assign tx_set = (try_tx && tx_found) ? tx_oh : '0;

    // Transmit allocation result and pending flag
    always_ff @(posedge clk) begin
        if (!rst_n || mmu_clear) begin
            alloc_result <= '0;
            alloc_pend   <= 1'b0;
        end else if (try_tx) begin
            alloc_result <= tx_found ? tx_pg : SENT;
            alloc_pend   <= !tx_found;
        end
    end

    // Receive queue
    page_fifo #(.DEPTH(NUM_PAGES), .W(PW)) u_rxq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (mmu_clear),
        .push      (rx_alloc_ok),
        .push_data (rx_alloc_page),
        .pop       ((cmd == CMD_RX_POP) || (cmd == CMD_RX_FREE)),
        .head      (rxq_head),
        .count     (rxq_cnt),
        .empty     (rxq_empty),
        .full      (rxq_full)
    );

    // Send queue
    page_fifo #(.DEPTH(NUM_PAGES), .W(PW)) u_txq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (tx_clear),
        .push      ((cmd == CMD_TX_QUEUE) && pnum_ok),
        .push_data (pnum),
        .pop       (launch),
        .head      (txq_head),
        .count     (txq_cnt),
        .empty     (txq_empty),
        .full      (txq_full)
    );

    // Completion queue
    page_fifo #(.DEPTH(NUM_PAGES), .W(PW)) u_doneq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (tx_clear),
        .push      (launch && !auto_release),
        .push_data (txq_head),
        .pop       (ack_we && ack_data[1]),
        .head      (dq_head),
        .count     (dq_cnt),
        .empty     (dq_empty),
        .full      (dq_full)
    );

    assign rx_head   = rxq_empty ? SENT : rxq_head;
    assign done_head = dq_empty ? SENT : dq_head;
    assign tx_launch = launch;
    assign tx_page   = txq_head;

    // Next stored status: acknowledge, allocation, receive and empty events
    always_comb begin
        stat_n = stat_q & ~(ack_we ? (ack_data & ACK_MASK) : 8'h00);
        if (cmd == CMD_TX_ALLOC) begin
            stat_n = tx_found ? (stat_n | ST_ALLOC) : (stat_n & ~ST_ALLOC);
        end else if (try_tx && tx_found) begin
            stat_n = stat_n | ST_ALLOC;
        end
        if (rx_alloc_ok) begin
            stat_n = stat_n | ST_RCV;
        end else if ((cmd == CMD_RX_POP) || (cmd == CMD_RX_FREE)) begin
            stat_n = (rxq_cnt > CW'(1)) ? (stat_n | ST_RCV) : (stat_n & ~ST_RCV);
        end
        if (txq_empty) begin
            stat_n = stat_n | ST_TXEMPTY;
        end
    end

    // Stored status bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= ST_TXEMPTY;
        end else begin
            stat_q <= stat_n;
        end
    end

    // Interrupt mask register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_mask <= 8'h00;
        end else if (mask_we) begin
            int_mask <= mask_data;
        end
    end

    // Packet-number register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pnum <= '0;
        end else if (pnum_we) begin
            pnum <= pnum_wdata;
        end
    end

    assign int_status = stat_q | (txq_empty ? ST_TXEMPTY : 8'h00)
                               | (dq_empty ? 8'h00 : ST_TX);
    assign irq = |(int_status & int_mask);

endmodule

// File: rtl/pkt_page_alloc_chk.sv
// Checker for the page allocator: port-level properties checked every cycle.
// Assumes: bound to every instance of pkt_page_alloc.
module pkt_page_alloc_chk #(
    parameter int NUM_PAGES = 4,
    parameter int PW        = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic [2:0]    cmd_code,
    input logic          tx_en,
    input logic          tx_launch,
    input logic          rx_alloc_ok,
    input logic [PW-1:0] rx_alloc_page,
    input logic [PW-1:0] rx_head,
    input logic [PW-1:0] alloc_result,
    input logic [7:0]    int_status,
    input logic [7:0]    int_mask,
    input logic          irq
);

    // R12: line follows status and mask
    a_r12_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
        irq == |(int_status & int_mask));

    // R8: launches need enable and no command in flight
    a_r8_launch_gated: assert property (@(posedge clk) disable iff (!rst_n)
        tx_launch |-> (tx_en && !cmd_valid));

    // R3: after an allocate command, ALLOC agrees with the result
    a_r3_alloc_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == 3'd1) |=> (int_status[3] == (alloc_result != PW'(8'h80))));

    // R3, R11: only an allocate command clears ALLOC
    a_r3_alloc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (int_status[3] && !(cmd_valid && cmd_code == 3'd1)) |=> int_status[3]);

    // R4: a granted page shows up at the receive head
    a_r4_rx_push: assert property (@(posedge clk) disable iff (!rst_n)
        rx_alloc_ok |=> (rx_head != PW'(8'h80)));

    // R2: granted page lies in range
    a_r2_pick_range: assert property (@(posedge clk) disable iff (!rst_n)
        rx_alloc_ok |-> (rx_alloc_page < PW'(NUM_PAGES)));

endmodule

bind pkt_page_alloc pkt_page_alloc_chk #(.NUM_PAGES(NUM_PAGES), .PW(PW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_code      (cmd_code),
    .tx_en         (tx_en),
    .tx_launch     (tx_launch),
    .rx_alloc_ok   (rx_alloc_ok),
    .rx_alloc_page (rx_alloc_page),
    .rx_head       (rx_head),
    .alloc_result  (alloc_result),
    .int_status    (int_status),
    .int_mask      (int_mask),
    .irq           (irq)
);

// File: tb/pkt_page_alloc_tb.sv
// Directed bench for the page allocator: one task per scenario.
module pkt_page_alloc_tb;

    localparam int NP = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_code = 3'd0;
    logic       pnum_we = 1'b0;
    logic [7:0] pnum_wdata = 8'd0;
    logic [7:0] pnum, alloc_result, rx_alloc_page, rx_head, done_head, tx_page;
    logic [2:0] pages_used;
    logic       rx_alloc_req = 1'b0;
    logic       rx_alloc_ok;
    logic       tx_en = 1'b0;
    logic       auto_release = 1'b0;
    logic       tx_launch;
    logic       ack_we = 1'b0;
    logic [7:0] ack_data = 8'd0;
    logic       mask_we = 1'b0;
    logic [7:0] mask_data = 8'd0;
    logic [7:0] int_status, int_mask;
    logic       irq;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    pkt_page_alloc #(.NUM_PAGES(NP), .PW(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .pnum_we(pnum_we), .pnum_wdata(pnum_wdata), .pnum(pnum),
        .alloc_result(alloc_result), .pages_used(pages_used),
        .rx_alloc_req(rx_alloc_req), .rx_alloc_ok(rx_alloc_ok),
        .rx_alloc_page(rx_alloc_page), .rx_head(rx_head), .done_head(done_head),
        .tx_en(tx_en), .auto_release(auto_release), .tx_launch(tx_launch),
        .tx_page(tx_page), .ack_we(ack_we), .ack_data(ack_data),
        .mask_we(mask_we), .mask_data(mask_data), .int_status(int_status),
        .int_mask(int_mask), .irq(irq)
    );

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // Each operation starts just after a falling edge and ends just after the next
    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic do_cmd(int code);
        cmd_valid = 1'b1;
        cmd_code  = 3'(code);
        @(negedge clk);
        cmd_valid = 1'b0;
        #1;
    endtask

    task automatic set_pnum(int v);
        pnum_we = 1'b1;
        pnum_wdata = 8'(v);
        @(negedge clk);
        pnum_we = 1'b0;
        #1;
    endtask

    task automatic do_ack(int v);
        ack_we = 1'b1;
        ack_data = 8'(v);
        @(negedge clk);
        ack_we = 1'b0;
        #1;
    endtask

    task automatic set_mask(int v);
        mask_we = 1'b1;
        mask_data = 8'(v);
        @(negedge clk);
        mask_we = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        chk("R1", "int_status", int_status, 8'h04);
        chk("R1", "int_mask", int_mask, 0);
        chk("R1", "irq", irq, 0);
        chk("R1", "alloc_result", alloc_result, 0);
        chk("R1", "pages_used", pages_used, 0);
        chk("R1", "rx_head", rx_head, 8'h80);
        chk("R1", "done_head", done_head, 8'h80);
    endtask

    task automatic t_tx_alloc();
        for (int i = 0; i < NP; i++) begin
            do_cmd(1);
            chk("R2", "lowest free page", alloc_result, i);
            chk("R3", "ALLOC after success", int_status[3], 1);
        end
        chk("R2", "pages_used full", pages_used, 4);
        do_cmd(1);
        chk("R2", "sentinel on full", alloc_result, 8'h80);
        chk("R3", "ALLOC cleared on failure", int_status[3], 0);
        set_pnum(2);
        chk("R6", "pnum readback", pnum, 2);
        do_cmd(5);
        chk("R3", "retry after release", alloc_result, 2);
        chk("R3", "ALLOC after retry", int_status[3], 1);
        chk("R6", "pages_used after retry", pages_used, 4);
        set_pnum(9);
        do_cmd(5);
        chk("R6", "out-of-range release ignored", pages_used, 4);
        do_cmd(2);
        chk("R13", "bitmap cleared", pages_used, 0);
        chk("R13", "result cleared", alloc_result, 0);
    endtask

    task automatic t_rx();
        rx_alloc_req = 1'b1;
        #1;
        chk("R4", "grant", rx_alloc_ok, 1);
        chk("R4", "offered page", rx_alloc_page, 0);
        step();
        chk("R4", "rx_head", rx_head, 0);
        chk("R4", "RCV set", int_status[0], 1);
        chk("R2", "next offered page", rx_alloc_page, 1);
        step();
        rx_alloc_req = 1'b0;
        do_cmd(3);
        chk("R5", "head after pop", rx_head, 1);
        chk("R5", "RCV kept", int_status[0], 1);
        do_cmd(4);
        chk("R5", "head after release-pop", rx_head, 8'h80);
        chk("R5", "RCV cleared", int_status[0], 0);
        chk("R5", "page freed", pages_used, 1);
        do_cmd(1);
        do_cmd(1);
        do_cmd(1);
        rx_alloc_req = 1'b1;
        #1;
        chk("R4", "no grant when full", rx_alloc_ok, 0);
        rx_alloc_req = 1'b0;
        do_cmd(2);
    endtask

    task automatic t_tx_done();
        set_pnum(1);
        do_cmd(6);
        chk("R10", "TX_EMPTY sticky", int_status[2], 1);
        do_ack(8'h04);
        chk("R10", "TX_EMPTY acked while queued", int_status[2], 0);
        tx_en = 1'b1;
        #1;
        chk("R8", "launch strobe", tx_launch, 1);
        chk("R8", "launched page", tx_page, 1);
        step();
        tx_en = 1'b0;
        chk("R8", "single pulse", tx_launch, 0);
        chk("R9", "completion head", done_head, 1);
        chk("R10", "TX set", int_status[1], 1);
        chk("R10", "TX_EMPTY back", int_status[2], 1);
        do_ack(8'h02);
        chk("R11", "completion popped", done_head, 8'h80);
        chk("R10", "TX clear", int_status[1], 0);
    endtask

    task automatic t_queue_full();
        int n_launch;
        int exp_pg;
        bit order_ok;
        for (int i = 0; i < NP; i++) begin
            set_pnum(i);
            do_cmd(6);
        end
        set_pnum(1);
        do_cmd(6);
        set_pnum(9);
        do_cmd(6);
        tx_en = 1'b1;
        n_launch = 0;
        exp_pg = 0;
        order_ok = 1;
        for (int c = 0; c < 6; c++) begin
            #1;
            if (tx_launch) begin
                if (tx_page != 8'(exp_pg)) order_ok = 0;
                exp_pg++;
                n_launch++;
            end
            step();
        end
        tx_en = 1'b0;
        chk("R7", "launch count with full queue", n_launch, 4);
        chk("R8", "launch order", order_ok, 1);
        for (int i = 0; i < NP; i++) begin
            chk("R9", "completion order", done_head, i);
            do_ack(8'h02);
        end
        chk("R9", "completion empty", done_head, 8'h80);
    endtask

    task automatic t_auto_release();
        do_cmd(2);
        for (int i = 0; i < NP; i++) do_cmd(1);
        do_cmd(1);
        chk("R3", "pending failure", alloc_result, 8'h80);
        set_pnum(2);
        do_cmd(6);
        auto_release = 1'b1;
        tx_en = 1'b1;
        step();
        tx_en = 1'b0;
        auto_release = 1'b0;
        chk("R9", "auto release skips completion", done_head, 8'h80);
        chk("R3", "retry on auto release", alloc_result, 2);
        chk("R3", "ALLOC on retry", int_status[3], 1);
        chk("R9", "pages_used", pages_used, 4);
    endtask

    task automatic t_ack_mask();
        do_ack(8'hFF);
        chk("R11", "ALLOC not ackable", int_status[3], 1);
        chk("R11", "upper bits clear", int_status[7:4], 0);
        set_mask(8'h08);
        chk("R12", "mask readback", int_mask, 8'h08);
        chk("R12", "irq high", irq, 1);
        set_mask(8'h00);
        chk("R12", "irq low", irq, 0);
    endtask

    task automatic t_clear7();
        set_pnum(0);
        do_cmd(6);
        do_cmd(7);
        tx_en = 1'b1;
        #1;
        chk("R13", "no launch after clear", tx_launch, 0);
        step();
        tx_en = 1'b0;
        chk("R13", "completion empty", done_head, 8'h80);
        chk("R13", "send queue empty", int_status[2], 1);
        chk("R13", "bitmap kept", pages_used, 4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_tx_alloc();
        t_rx();
        t_tx_done();
        t_queue_full();
        t_auto_release();
        t_ack_mask();
        t_clear7();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule